// File: doc/BRIEF.md
# Double-Pumped Four-Read Two-Write Register Array

This block is a behavioural model of a 64-word by 24-bit storage array built around a two-read, one-write core that is run twice per system clock. Each system cycle therefore carries two array half-cycles. The first half-cycle serves read ports 0 and 1 together with write port 0. The second half-cycle serves read ports 2 and 3 together with write port 1. Seen from the system clock, the block offers four read ports and two write ports.

Every port's strobe and 6-bit address first go through a predecoder. The predecoder produces three one-hot groups of four lines. A word-line decoder then turns those groups into 64 one-hot word selects. The read path is modelled as a hierarchy. Eight subarrays of 16 words by 12 bits are arranged as four row groups by two column halves. Each subarray's read lines are merged with its neighbouring row group in a local stage. The output for each column half is then taken from the two local results.

Requests are sampled on the rising clock edge. Read results from all four ports appear together on the registered output one system cycle later.

Top module: `dpra_top`

## Requirements
- R1: After reset every word holds zero and `rd_data` is zero.
- R2: A read strobed at rising edge k places the addressed word on its `rd_data` slice after edge k. Port p uses `rd_addr[p*6 +: 6]` and `rd_data[p*24 +: 24]`. The value holds until edge k+1.
- R3: A read port whose strobe is low at an edge outputs zero after that edge, whatever its address.
- R4: A write port whose strobe is low leaves the storage unchanged. Write port k uses `wr_addr[k*6 +: 6]` and `wr_data[k*24 +: 24]`.
- R5: Each port's predecoder drives three groups of four lines. Group g has line n high exactly when the strobe is high and address bits [2g+1:2g] equal n. All twelve lines are low when the strobe is low.
- R6: Each port's word selects are one-hot while its strobe is high and all zero while it is low.
- R7: Read ports 0 and 1 return the data held before either write of the same cycle.
- R8: Read ports 2 and 3 see write port 0 of the same cycle but not write port 1.
- R9: When both write ports target one address in the same cycle, write port 1's data is kept.
- R10: All 64 words and all 24 bits are stored and read back independently, across every row group and both column halves.
- R11: Two read ports of the same half-cycle that address the same word return identical data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 4 | Read strobe, one bit per read port |
| rd_addr | input | 24 | Read addresses, 6 bits per port, port p at bits p*6 |
| wr_stb | input | 2 | Write strobe, one bit per write port |
| wr_addr | input | 12 | Write addresses, 6 bits per port, port k at bits k*6 |
| wr_data | input | 48 | Write data, 24 bits per port, port k at bits k*24 |
| rd_data | output | 96 | Registered read data, 24 bits per port, port p at bits p*24 |

## Verification
Every read result is due one rising edge after its request. The bench drives a request at a falling edge. It then lets one rising edge pass and compares all four `rd_data` slices at the following falling edge against the value its reference predicted for that request. A write shows only through later reads. The reference therefore applies write port 0 between the first-half and second-half reads of a cycle, and write port 1 after both, so that the same-cycle visibility of R7, R8 and R9 is judged at the very next falling edge. The predecode and word-select properties are held every cycle by the bound checker.

// File: rtl/dpra_pkg.sv
package dpra_pkg;

    localparam int unsigned DEF_ADDR_W     = 6;
    localparam int unsigned DEF_DATA_W     = 24;
    localparam int unsigned DEF_N_RD       = 4;
    localparam int unsigned DEF_N_WR       = 2;
    localparam int unsigned DEF_ROW_GRPS   = 4;
    localparam int unsigned DEF_COL_HALVES = 2;

    // Half-cycle in which a read port is served: ports are spread evenly
    // over the write slots, lowest ports first.
    function automatic int unsigned phase_of(int unsigned port, int unsigned per_phase);
        return port / per_phase;
    endfunction

endpackage

// File: rtl/dpra_predec.sv
module dpra_predec #(
    parameter int unsigned ADDR_W = 6
) (
    input  logic                     stb,
    input  logic [ADDR_W-1:0]        addr,
    output logic [(ADDR_W/2)*4-1:0]  lines
);
    localparam int unsigned GRPS = ADDR_W / 2;

    for (genvar g = 0; g < GRPS; g++) begin : g_grp
        for (genvar n = 0; n < 4; n++) begin : g_line
            assign lines[g*4 + n] = stb && (addr[2*g +: 2] == 2'(n));
        end
    end
endmodule

// File: rtl/dpra_wldec.sv
module dpra_wldec #(
    parameter int unsigned ADDR_W = 6
) (
    input  logic [(ADDR_W/2)*4-1:0] lines,
    output logic [(1<<ADDR_W)-1:0]  wsel
);
    localparam int unsigned GRPS  = ADDR_W / 2;
    localparam int unsigned WORDS = 1 << ADDR_W;

    always_comb begin
        for (int w = 0; w < WORDS; w++) begin
            wsel[w] = 1'b1;
            for (int g = 0; g < GRPS; g++) begin
                wsel[w] = wsel[w] & lines[g*4 + ((w >> (2*g)) & 3)];
            end
        end
    end
endmodule

// File: rtl/dpra_rdtree.sv
module dpra_rdtree #(
    parameter int unsigned WORDS      = 64,
    parameter int unsigned DATA_W     = 24,
    parameter int unsigned ROW_GRPS   = 4,
    parameter int unsigned COL_HALVES = 2
) (
    input  logic [WORDS-1:0][DATA_W-1:0] mem,
    input  logic [WORDS-1:0]             wsel,
    output logic [DATA_W-1:0]            dout
);
    localparam int unsigned SUB_WORDS = WORDS / ROW_GRPS;
    localparam int unsigned SUB_BITS  = DATA_W / COL_HALVES;
    localparam int unsigned N_LOCAL   = ROW_GRPS / 2;

    // Unselected words contribute zero, so each subarray is a wide OR.
    function automatic logic [SUB_BITS-1:0] sub_read(
        input logic [WORDS-1:0][DATA_W-1:0] m,
        input logic [WORDS-1:0]             s,
        input int                           g,
        input int                           h
    );
        logic [SUB_BITS-1:0] acc;
        acc = '0;
        for (int i = 0; i < SUB_WORDS; i++) begin
            if (s[g*SUB_WORDS + i]) acc = acc | m[g*SUB_WORDS + i][h*SUB_BITS +: SUB_BITS];
        end
        return acc;
    endfunction

    logic [COL_HALVES-1:0][ROW_GRPS-1:0][SUB_BITS-1:0] sub_bus;
    logic [COL_HALVES-1:0][N_LOCAL-1:0][SUB_BITS-1:0]  loc_bus;

    for (genvar h = 0; h < COL_HALVES; h++) begin : g_half
        for (genvar g = 0; g < ROW_GRPS; g++) begin : g_sub
            assign sub_bus[h][g] = sub_read(mem, wsel, g, h);
        end
        // Local stage: each subarray paired with its neighbour row group.
        for (genvar l = 0; l < N_LOCAL; l++) begin : g_loc
            assign loc_bus[h][l] = sub_bus[h][2*l] | sub_bus[h][2*l+1];
        end
    end

    // Final stage: per column half, take the active local result.
    always_comb begin
        dout = '0;
        for (int h = 0; h < COL_HALVES; h++) begin
            for (int l = 0; l < N_LOCAL; l++) begin
                dout[h*SUB_BITS +: SUB_BITS] = dout[h*SUB_BITS +: SUB_BITS] | loc_bus[h][l];
            end
        end
    end
endmodule

// File: rtl/dpra_top.sv
module dpra_top
    import dpra_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned DATA_W     = DEF_DATA_W,
    parameter int unsigned N_RD       = DEF_N_RD,
    parameter int unsigned N_WR       = DEF_N_WR,
    parameter int unsigned ROW_GRPS   = DEF_ROW_GRPS,
    parameter int unsigned COL_HALVES = DEF_COL_HALVES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_RD-1:0]          rd_stb,
    input  logic [N_RD*ADDR_W-1:0]   rd_addr,
    input  logic [N_WR-1:0]          wr_stb,
    input  logic [N_WR*ADDR_W-1:0]   wr_addr,
    input  logic [N_WR*DATA_W-1:0]   wr_data,
    output logic [N_RD*DATA_W-1:0]   rd_data
);
    localparam int unsigned WORDS     = 1 << ADDR_W;
    localparam int unsigned NLINES    = (ADDR_W / 2) * 4;
    localparam int unsigned RD_PER_PH = N_RD / N_WR;

    typedef struct packed {
        logic [WORDS-1:0][DATA_W-1:0] mem;
        logic [N_RD-1:0][DATA_W-1:0]  rdat;
    } state_t;

    state_t st_d, st_q;

    logic [N_RD-1:0][NLINES-1:0]  rd_lines;
    logic [N_WR-1:0][NLINES-1:0]  wr_lines;
    logic [N_RD-1:0][WORDS-1:0]   rd_wsel;
    logic [N_WR-1:0][WORDS-1:0]   wr_wsel;
    logic [N_RD-1:0][DATA_W-1:0]  rd_word;
    logic [WORDS-1:0][DATA_W-1:0] mem_stage [N_WR+1];

    // Write port decode
    for (genvar k = 0; k < N_WR; k++) begin : g_wr
        dpra_predec #(.ADDR_W(ADDR_W)) u_pre (
            .stb   (wr_stb[k]),
            .addr  (wr_addr[k*ADDR_W +: ADDR_W]),
            .lines (wr_lines[k])
        );
        dpra_wldec #(.ADDR_W(ADDR_W)) u_dec (
            .lines (wr_lines[k]),
            .wsel  (wr_wsel[k])
        );
    end

    // Half-cycle chain: stage k is the array content seen in half-cycle k.
    always_comb begin
        mem_stage[0] = st_q.mem;
        for (int k = 0; k < N_WR; k++) begin
            mem_stage[k+1] = mem_stage[k];
            for (int w = 0; w < WORDS; w++) begin
                if (wr_wsel[k][w]) mem_stage[k+1][w] = wr_data[k*DATA_W +: DATA_W];
            end
        end
    end

    // Read ports, each reading the content of its own half-cycle
    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        localparam int unsigned PH = phase_of(p, RD_PER_PH);
        dpra_predec #(.ADDR_W(ADDR_W)) u_pre (
            .stb   (rd_stb[p]),
            .addr  (rd_addr[p*ADDR_W +: ADDR_W]),
            .lines (rd_lines[p])
        );
        dpra_wldec #(.ADDR_W(ADDR_W)) u_dec (
            .lines (rd_lines[p]),
            .wsel  (rd_wsel[p])
        );
        dpra_rdtree #(
            .WORDS      (WORDS),
            .DATA_W     (DATA_W),
            .ROW_GRPS   (ROW_GRPS),
            .COL_HALVES (COL_HALVES)
        ) u_tree (
            .mem  (mem_stage[PH]),
            .wsel (rd_wsel[p]),
            .dout (rd_word[p])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.mem  = mem_stage[N_WR];
        st_d.rdat = rd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rdat;
endmodule

// File: rtl/dpra_top_chk.sv
module dpra_top_chk #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 24,
    parameter int unsigned N_RD   = 4,
    parameter int unsigned N_WR   = 2
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic [N_RD-1:0]                      rd_stb,
    input logic [N_RD*ADDR_W-1:0]               rd_addr,
    input logic [N_WR-1:0]                      wr_stb,
    input logic [N_RD*DATA_W-1:0]               rd_data,
    input logic [N_RD-1:0][(ADDR_W/2)*4-1:0]    rd_lines,
    input logic [N_RD-1:0][(1<<ADDR_W)-1:0]     rd_wsel,
    input logic [N_WR-1:0][(1<<ADDR_W)-1:0]     wr_wsel
);
    localparam int unsigned GRPS = ADDR_W / 2;

    for (genvar p = 0; p < N_RD; p++) begin : g_port
        // R5
        pre_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_stb[p] |-> (rd_lines[p] == '0));
        for (genvar g = 0; g < GRPS; g++) begin : g_grp
            // R5
            pre_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rd_stb[p] |-> ($countones(rd_lines[p][g*4 +: 4]) == 1));
        end
        // R6
        wsel_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_stb[p] |-> ($countones(rd_wsel[p]) == 1));
        // R6
        wsel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_stb[p] |-> (rd_wsel[p] == '0));
        // R3
        idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_stb[p] |=> (rd_data[p*DATA_W +: DATA_W] == '0));
    end

    for (genvar k = 0; k < N_WR; k++) begin : g_wport
        // R6
        wr_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(wr_wsel[k]));
    end

    // R11
    same_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb[0] && rd_stb[1] && (rd_addr[0 +: ADDR_W] == rd_addr[ADDR_W +: ADDR_W]))
        |=> (rd_data[0 +: DATA_W] == rd_data[DATA_W +: DATA_W]));

    // R7
    quiet_halves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb[0] && rd_stb[N_RD-1] && (wr_stb == '0)
         && (rd_addr[0 +: ADDR_W] == rd_addr[(N_RD-1)*ADDR_W +: ADDR_W]))
        |=> (rd_data[0 +: DATA_W] == rd_data[(N_RD-1)*DATA_W +: DATA_W]));
endmodule

bind dpra_top dpra_top_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .N_RD   (N_RD),
    .N_WR   (N_WR)
) u_chk (.*);

// File: tb/dpra_top_test.sv
module dpra_top_test;
    localparam int AW = 6;
    localparam int DW = 24;
    localparam int NR = 4;
    localparam int NW = 2;
    localparam int NWORDS = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NR-1:0]     rd_stb = '0;
    logic [NR*AW-1:0]  rd_addr = '0;
    logic [NW-1:0]     wr_stb = '0;
    logic [NW*AW-1:0]  wr_addr = '0;
    logic [NW*DW-1:0]  wr_data = '0;
    logic [NR*DW-1:0]  rd_data;

    int checks = 0;
    int bad = 0;

    logic [DW-1:0] ref_mem [NWORDS];
    logic [DW-1:0] expv [NR];

    always #5 clk = ~clk;

    dpra_top uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .rd_addr (rd_addr),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    function automatic logic [DW-1:0] pat(int a);
        logic [5:0] b;
        b = 6'(a);
        return {b, ~b, 12'hA5C ^ {6'h0, b}};
    endfunction

    task automatic clear_req();
        rd_stb = '0; rd_addr = '0; wr_stb = '0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic rd(int p, int a);
        rd_stb[p] = 1'b1;
        rd_addr[p*AW +: AW] = AW'(a);
    endtask

    task automatic wr(int k, int a, logic [DW-1:0] d);
        wr_stb[k] = 1'b1;
        wr_addr[k*AW +: AW] = AW'(a);
        wr_data[k*DW +: DW] = d;
    endtask

    task automatic check(string tag, int p, logic [DW-1:0] got, logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s port %0d got %h expected %h", tag, p, got, exp);
        end
    endtask

    // Reference: reads of half-cycle k see writes 0..k-1 of the same cycle.
    task automatic cyc(string tag);
        for (int ph = 0; ph <= NW; ph++) begin
            for (int p = 0; p < NR; p++) begin
                if (p / (NR / NW) == ph)
                    expv[p] = rd_stb[p] ? ref_mem[rd_addr[p*AW +: AW]] : '0;
            end
            if (ph < NW && wr_stb[ph])
                ref_mem[wr_addr[ph*AW +: AW]] = wr_data[ph*DW +: DW];
        end
        @(posedge clk);
        @(negedge clk);
        for (int p = 0; p < NR; p++) check(tag, p, rd_data[p*DW +: DW], expv[p]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NWORDS; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state at the output
        for (int p = 0; p < NR; p++) check("R1", p, rd_data[p*DW +: DW], '0);
        rst_n = 1'b1;

        // R1: every word reads zero after reset
        for (int c = 0; c < NWORDS / NR; c++) begin
            clear_req();
            for (int p = 0; p < NR; p++) rd(p, c*NR + p);
            cyc("R1");
        end

        // R10: fill every word, two per cycle, then read all back
        for (int c = 0; c < NWORDS / NW; c++) begin
            clear_req();
            wr(0, 2*c, pat(2*c));
            wr(1, 2*c+1, pat(2*c+1));
            cyc("R10");
        end
        for (int c = 0; c < NWORDS / NR; c++) begin
            clear_req();
            for (int p = 0; p < NR; p++) rd(p, NWORDS - 1 - (c*NR + p));
            cyc("R10");
        end

        // R4: unstrobed writes with live address and data
        clear_req();
        wr_addr = {6'd5, 6'd5};
        wr_data = {24'hFFFFFF, 24'h123456};
        cyc("R4");
        clear_req();
        rd(0, 5); rd(3, 5);
        cyc("R4");

        // R3: unstrobed read ports with nonzero addresses
        clear_req();
        rd_addr = {6'd63, 6'd7, 6'd12, 6'd40};
        rd(1, 40);
        rd_stb = 4'b0010;
        cyc("R3");

        // R7 / R8: half-cycle visibility of same-cycle writes
        clear_req();
        wr(0, 7, 24'hC0FFEE);
        wr(1, 9, 24'h0BEEF1);
        rd(0, 7); rd(1, 9); rd(2, 7); rd(3, 9);
        cyc("R7_R8");
        clear_req();
        rd(0, 9); rd(2, 7);
        cyc("R8");

        // R9: both writes to one address, port 1 wins
        clear_req();
        wr(0, 12, 24'h111111);
        wr(1, 12, 24'h222222);
        rd(1, 12); rd(2, 12);
        cyc("R9");
        clear_req();
        rd(0, 12); rd(3, 12);
        cyc("R9");

        // R11: same word on both ports of each half
        clear_req();
        rd(0, 33); rd(1, 33); rd(2, 50); rd(3, 50);
        cyc("R11");

        // R2: randomized traffic with frequent address collisions
        for (int c = 0; c < 1500; c++) begin
            clear_req();
            for (int p = 0; p < NR; p++) begin
                if ($urandom_range(0, 3) != 0)
                    rd(p, ($urandom_range(0, 1) != 0) ? $urandom_range(0, 7) : $urandom_range(0, 63));
            end
            for (int k = 0; k < NW; k++) begin
                if ($urandom_range(0, 1) != 0)
                    wr(k, ($urandom_range(0, 1) != 0) ? $urandom_range(0, 7) : $urandom_range(0, 63),
                       DW'($urandom()));
            end
            cyc("R2");
        end

        clear_req();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule